// File: doc/BRIEF.md
# Five-Port Single-Flit Mesh Router

This block steers traffic at one node of a two-dimensional mesh. It has five bidirectional ports: four face the neighbouring nodes (north, south, east, west) and one faces the local processing element. Every packet is a single 80-bit flit. The flit carries its destination coordinates next to its payload. The router therefore keeps no per-packet state and never holds a path open from one cycle to the next.

Each input captures arriving flits in a two-entry buffer. The head flit of each buffer is routed on its destination coordinates: the column is resolved first, then the row. Each output picks one of the inputs that want it with its own round-robin arbiter. No register lies between a buffer head and an output, so a stored flit reaches the neighbour within the same cycle. All five outputs can carry a flit in one cycle. Every port uses a valid/ready handshake, and a transfer happens on a rising edge where both are high.

The router learns its own position from two coordinate inputs. This lets one netlist be placed at any node of the mesh.

Top module: `mesh_router`

## Requirements
- R1: Port index 0 is north, 1 is south, 2 is east, 3 is west and 4 is local. The flit of port p occupies bits [80*p+79 : 80*p] of the flat flit buses, and bit p of each valid/ready bus belongs to port p.
- R2: Each input stores at most two flits. Its in_ready is high exactly when fewer than two flits are stored. A flit offered while in_ready is low is not taken.
- R3: Flit layout: control in bits [79:64], data in [63:32], destination row Y in [31:27], destination column X in [26:22] and memory address in [21:0]. The router forwards all 80 bits unchanged.
- R4: The column is resolved first. A flit whose X is greater than my_x leaves east, and one whose X is smaller leaves west, whatever its Y.
- R5: When X equals my_x, a flit whose Y is greater than my_y leaves south, one whose Y is smaller leaves north, and one whose Y equals my_y leaves on the local port.
- R6: Each output has a rotating pointer that resets to input 0. Among the buffer heads that want that output, the grant goes to the first input found when counting cyclically upward from the pointer.
- R7: An output's pointer moves to one past the granted input only on an edge where that output's valid and ready are both high. On any other edge it holds.
- R8: A flit accepted at a clock edge is presented on its output port directly after that edge. It leaves on the first edge at which it is granted and the output's ready is high.
- R9: All five outputs can each complete a transfer on the same clock edge.
- R10: A flit waits in its buffer while its output is not ready. Flits from one input leave in the order they arrived.
- R11: After reset every in_ready is high and every out_valid is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| my_x | input | 5 | Column coordinate of this node |
| my_y | input | 5 | Row coordinate of this node |
| in_flit | input | 400 | Incoming flits, one 80-bit lane per port |
| in_valid | input | 5 | Incoming flit present, per port |
| in_ready | output | 5 | Input buffer has a free slot, per port |
| out_flit | output | 400 | Outgoing flits, one 80-bit lane per port |
| out_valid | output | 5 | Outgoing flit present, per port |
| out_ready | input | 5 | Neighbour accepts a flit, per port |

## Verification
Contention for one output and a stalled neighbour can occur in the same cycle. This is the case where the round-robin pointer is most easily disturbed. The bench parks a flit from the north input on a blocked local output for several cycles. It then adds a contender from the west and releases the output. A correct pointer gives the grant to north, and a pointer that drifted during the stall gives it to west. The bench also refills an input on the very edge at which its head leaves, and checks that the freed slot is reused without reordering the stream.

// File: rtl/mesh_router_pkg.sv
package mesh_router_pkg;
    localparam int NPORT   = 5;
    localparam int PORT_N  = 0;
    localparam int PORT_S  = 1;
    localparam int PORT_E  = 2;
    localparam int PORT_W  = 3;
    localparam int PORT_L  = 4;
    localparam int CTRL_W  = 16;
    localparam int DATA_W  = 32;
    localparam int COORD_W = 5;
    localparam int ADDR_W  = 22;

    typedef struct packed {
        logic [CTRL_W-1:0]  ctrl;
        logic [DATA_W-1:0]  data;
        logic [COORD_W-1:0] dst_y;
        logic [COORD_W-1:0] dst_x;
        logic [ADDR_W-1:0]  addr;
    } flit_t;

    localparam int FLIT_W = $bits(flit_t);
endpackage

// File: rtl/router_fifo.sv
module router_fifo #(
    parameter int DEPTH = 2,
    parameter int W     = 80,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_valid,
    output logic          push_ready,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic          head_valid,
    output logic [W-1:0]  head_data,
    output logic [CW-1:0] count
);
    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           wr;
        logic [PW-1:0]           rd;
        logic [CW-1:0]           cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic     do_push, do_pop;

    always_comb begin
        st_d    = st_q;
        do_push = push_valid && (st_q.cnt < CW'(DEPTH));
        do_pop  = pop && (st_q.cnt != '0);
        if (do_push) begin
            st_d.mem[st_q.wr] = push_data;
            st_d.wr = (st_q.wr == PW'(DEPTH - 1)) ? '0 : st_q.wr + 1'b1;
        end
        if (do_pop) begin
            st_d.rd = (st_q.rd == PW'(DEPTH - 1)) ? '0 : st_q.rd + 1'b1;
        end
        if (do_push && !do_pop) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end else if (do_pop && !do_push) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign push_ready = (st_q.cnt < CW'(DEPTH));
    assign head_valid = (st_q.cnt != '0);
    assign head_data  = st_q.mem[st_q.rd];
    assign count      = st_q.cnt;
endmodule

// File: rtl/route_calc.sv
module route_calc
    import mesh_router_pkg::*;
(
    input  logic [COORD_W-1:0] dst_x,
    input  logic [COORD_W-1:0] dst_y,
    input  logic [COORD_W-1:0] my_x,
    input  logic [COORD_W-1:0] my_y,
    output logic [NPORT-1:0]   dir
);
    always_comb begin
        dir = '0;
        if (dst_x > my_x) begin
            dir[PORT_E] = 1'b1;
        end else if (dst_x < my_x) begin
            dir[PORT_W] = 1'b1;
        end else if (dst_y > my_y) begin
            dir[PORT_S] = 1'b1;
        end else if (dst_y < my_y) begin
            dir[PORT_N] = 1'b1;
        end else begin
            dir[PORT_L] = 1'b1;
        end
    end
endmodule

// File: rtl/rr_arbiter.sv
module rr_arbiter #(
    parameter int N   = 5,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    input  logic          accept,
    output logic [N-1:0]  grant,
    output logic          any,
    output logic [IW-1:0] ptr
);
    typedef struct packed {
        logic [IW-1:0] ptr;
    } arb_st_t;

    arb_st_t       st_d, st_q;
    logic [IW-1:0] win;

    always_comb begin
        grant = '0;
        win   = '0;
        any   = 1'b0;
        for (int k = 0; k < N; k++) begin
            int idx;
            idx = (int'(st_q.ptr) + k) % N;
            if (!any && req[idx]) begin
                any        = 1'b1;
                win        = IW'(idx);
                grant[idx] = 1'b1;
            end
        end
        st_d = st_q;
        if (accept && any) begin
            st_d.ptr = (win == IW'(N - 1)) ? '0 : win + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ptr = st_q.ptr;
endmodule

// File: rtl/mesh_router.sv
module mesh_router
    import mesh_router_pkg::*;
#(
    parameter int FIFO_DEPTH = 2,
    localparam int FW        = FLIT_W,
    localparam int IW        = $clog2(NPORT),
    localparam int CW        = $clog2(FIFO_DEPTH + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [COORD_W-1:0]    my_x,
    input  logic [COORD_W-1:0]    my_y,
    input  logic [NPORT*FW-1:0]   in_flit,
    input  logic [NPORT-1:0]      in_valid,
    output logic [NPORT-1:0]      in_ready,
    output logic [NPORT*FW-1:0]   out_flit,
    output logic [NPORT-1:0]      out_valid,
    input  logic [NPORT-1:0]      out_ready
);
    flit_t                         head [NPORT];
    logic [NPORT-1:0]              head_valid;
    logic [NPORT-1:0]              pop;
    logic [NPORT-1:0][NPORT-1:0]   dir_m;
    logic [NPORT-1:0][NPORT-1:0]   req_m;
    logic [NPORT-1:0][NPORT-1:0]   grant_m;
    logic [NPORT-1:0][FW-1:0]      out_m;
    logic [NPORT*NPORT-1:0]        grant_flat;
    logic [NPORT*IW-1:0]           ptr_flat;
    logic [NPORT*CW-1:0]           cnt_flat;
    logic [NPORT-1:0]              push_flat;

    for (genvar i = 0; i < NPORT; i++) begin : g_in
        logic [FW-1:0] head_raw;
        router_fifo #(
            .DEPTH (FIFO_DEPTH),
            .W     (FW)
        ) u_fifo (
            .clk        (clk),
            .rst_n      (rst_n),
            .push_valid (in_valid[i]),
            .push_ready (in_ready[i]),
            .push_data  (in_flit[i*FW +: FW]),
            .pop        (pop[i]),
            .head_valid (head_valid[i]),
            .head_data  (head_raw),
            .count      (cnt_flat[i*CW +: CW])
        );
        assign head[i]      = flit_t'(head_raw);
        assign push_flat[i] = in_valid[i] && in_ready[i];

        route_calc u_route (
            .dst_x (head[i].dst_x),
            .dst_y (head[i].dst_y),
            .my_x  (my_x),
            .my_y  (my_y),
            .dir   (dir_m[i])
        );
    end

    always_comb begin
        for (int o = 0; o < NPORT; o++) begin
            for (int i = 0; i < NPORT; i++) begin
                req_m[o][i] = head_valid[i] && dir_m[i][o];
            end
        end
    end

    for (genvar o = 0; o < NPORT; o++) begin : g_out
        rr_arbiter #(
            .N (NPORT)
        ) u_arb (
            .clk    (clk),
            .rst_n  (rst_n),
            .req    (req_m[o]),
            .accept (out_ready[o]),
            .grant  (grant_m[o]),
            .any    (out_valid[o]),
            .ptr    (ptr_flat[o*IW +: IW])
        );
        assign grant_flat[o*NPORT +: NPORT] = grant_m[o];
    end

    always_comb begin
        pop = '0;
        for (int o = 0; o < NPORT; o++) begin
            out_m[o] = '0;
            for (int i = 0; i < NPORT; i++) begin
                if (grant_m[o][i]) begin
                    out_m[o] = out_m[o] | FW'(head[i]);
                    pop[i]   = pop[i] | out_ready[o];
                end
            end
        end
    end

    assign out_flit = out_m;
endmodule

// File: rtl/mesh_router_chk.sv
module mesh_router_chk #(
    parameter int N     = 5,
    parameter int IW    = 3,
    parameter int CW    = 2,
    parameter int DEPTH = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic [N*N-1:0]  grant,
    input logic [N*IW-1:0] ptr,
    input logic [N*CW-1:0] cnt,
    input logic [N-1:0]    push,
    input logic [N-1:0]    pop,
    input logic [N-1:0]    out_valid,
    input logic [N-1:0]    out_ready
);
    logic [N-1:0][N-1:0] col;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            for (int o = 0; o < N; o++) begin
                col[i][o] = grant[o*N + i];
            end
        end
    end

    for (genvar o = 0; o < N; o++) begin : g_o
        // R6
        grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(grant[o*N +: N]));
        // R7
        ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(out_valid[o] && out_ready[o]) |=> $stable(ptr[o*IW +: IW]));
    end

    for (genvar i = 0; i < N; i++) begin : g_i
        // R2
        no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            cnt[i*CW +: CW] <= CW'(DEPTH));
        // R10
        drain_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (pop[i] && !push[i] && cnt[i*CW +: CW] != '0)
            |=> cnt[i*CW +: CW] == $past(cnt[i*CW +: CW]) - 1'b1);
        // R5
        single_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(col[i]) <= 1);
    end
endmodule

bind mesh_router mesh_router_chk #(
    .N     (mesh_router_pkg::NPORT),
    .IW    (IW),
    .CW    (CW),
    .DEPTH (FIFO_DEPTH)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .grant     (grant_flat),
    .ptr       (ptr_flat),
    .cnt       (cnt_flat),
    .push      (push_flat),
    .pop       (pop),
    .out_valid (out_valid),
    .out_ready (out_ready)
);

// File: tb/sim_mesh_router.sv
module sim_mesh_router;
    localparam int NP = 5;
    localparam int FW = 80;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [4:0]       my_x = 5'd2;
    logic [4:0]       my_y = 5'd2;
    logic [NP*FW-1:0] in_flit = '0;
    logic [NP-1:0]    in_valid = '0;
    logic [NP-1:0]    in_ready;
    logic [NP*FW-1:0] out_flit;
    logic [NP-1:0]    out_valid;
    logic [NP-1:0]    out_ready = '0;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    mesh_router u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .my_x      (my_x),
        .my_y      (my_y),
        .in_flit   (in_flit),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .out_flit  (out_flit),
        .out_valid (out_valid),
        .out_ready (out_ready)
    );

    function automatic logic [79:0] mk(input logic [4:0] x, input logic [4:0] y,
                                       input logic [31:0] d);
        return {16'hA5C3, d, y, x, 22'h2B1F7};
    endfunction

    task automatic check(input string req, input logic [79:0] act, input logic [79:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        in_valid  = '0;
        out_ready = '0;
        rst_n     = 1'b0;
        tick();
        tick();
        rst_n = 1'b1;
        tick();
    endtask

    task automatic t_reset();
        do_reset();
        check("R11 in_ready", 80'(in_ready), 80'h1F);
        check("R11 out_valid", 80'(out_valid), 80'h0);
    endtask

    task automatic route_one(input logic [4:0] x, input logic [4:0] y,
                             input int exp_port, input string req);
        logic [79:0] f;
        f = mk(x, y, 32'hD000_0000 | {27'd0, x} | ({27'd0, y} << 8));
        in_flit[4*FW +: FW] = f;
        in_valid[4] = 1'b1;
        tick();
        in_valid[4] = 1'b0;
        // R8: visible right after the accepting edge
        check({req, " R8 out_valid"}, 80'(out_valid), 80'(5'b1 << exp_port));
        // R1 R3: lane position and unchanged bits
        check({req, " R3 R1 flit"}, out_flit[exp_port*FW +: FW], f);
        tick();
        check({req, " R8 drained"}, 80'(out_valid), 80'h0);
    endtask

    task automatic t_route();
        do_reset();
        out_ready = 5'h1F;
        route_one(5'd3, 5'd0, 2, "R4 east");
        route_one(5'd0, 5'd4, 3, "R4 west");
        route_one(5'd2, 5'd4, 1, "R5 south");
        route_one(5'd2, 5'd0, 0, "R5 north");
        route_one(5'd2, 5'd2, 4, "R5 local");
    endtask

    task automatic t_fifo();
        logic [79:0] a, b, c;
        do_reset();
        a = mk(5'd2, 5'd2, 32'h0000_00A1);
        b = mk(5'd2, 5'd2, 32'h0000_00B2);
        c = mk(5'd2, 5'd2, 32'h0000_00C3);
        in_flit[3*FW +: FW] = a;
        in_valid[3] = 1'b1;
        tick();
        in_flit[3*FW +: FW] = b;
        tick();
        check("R2 full ready low", 80'(in_ready[3]), 80'h0);
        in_flit[3*FW +: FW] = c;
        tick();
        tick();
        check("R10 held head", out_flit[4*FW +: FW], a);
        check("R2 still full", 80'(in_ready[3]), 80'h0);
        out_ready[4] = 1'b1;
        tick();
        check("R10 order second", out_flit[4*FW +: FW], b);
        check("R2 slot freed", 80'(in_ready[3]), 80'h1);
        tick();
        in_valid[3] = 1'b0;
        check("R10 order third", out_flit[4*FW +: FW], c);
        check("R2 refill same edge", 80'(out_valid[4]), 80'h1);
        tick();
        check("R2 rejected flit absent", 80'(out_valid), 80'h0);
        out_ready = '0;
    endtask

    task automatic t_rr();
        do_reset();
        for (int p = 0; p < 4; p++) begin
            in_flit[p*FW +: FW] = mk(5'd2, 5'd2, 32'(p + 16));
        end
        in_valid = 5'b01111;
        tick();
        in_valid = '0;
        out_ready[4] = 1'b1;
        for (int k = 0; k < 4; k++) begin
            check("R6 rr order", out_flit[4*FW +: FW], mk(5'd2, 5'd2, 32'(k + 16)));
            tick();
        end
        check("R6 all served", 80'(out_valid), 80'h0);
        out_ready = '0;
    endtask

    task automatic t_stall();
        do_reset();
        in_flit[0*FW +: FW] = mk(5'd2, 5'd2, 32'h0000_0E01);
        in_valid[0] = 1'b1;
        tick();
        in_valid[0] = 1'b0;
        tick();
        tick();
        tick();
        in_flit[3*FW +: FW] = mk(5'd2, 5'd2, 32'h0000_0E02);
        in_valid[3] = 1'b1;
        tick();
        in_valid[3] = 1'b0;
        check("R7 stall keeps pointer", out_flit[4*FW +: FW], mk(5'd2, 5'd2, 32'h0000_0E01));
        out_ready[4] = 1'b1;
        tick();
        check("R7 advance after accept", out_flit[4*FW +: FW], mk(5'd2, 5'd2, 32'h0000_0E02));
        tick();
        in_flit[0*FW +: FW] = mk(5'd2, 5'd2, 32'h0000_0E03);
        in_flit[4*FW +: FW] = mk(5'd2, 5'd2, 32'h0000_0E04);
        in_valid = 5'b10001;
        out_ready[4] = 1'b0;
        tick();
        in_valid = '0;
        check("R7 pointer past west", out_flit[4*FW +: FW], mk(5'd2, 5'd2, 32'h0000_0E04));
        out_ready[4] = 1'b1;
        tick();
        check("R6 wraps to north", out_flit[4*FW +: FW], mk(5'd2, 5'd2, 32'h0000_0E03));
        tick();
        out_ready = '0;
    endtask

    task automatic t_parallel();
        logic [79:0] f [NP];
        do_reset();
        f[0] = mk(5'd2, 5'd3, 32'h1111_0000);
        f[1] = mk(5'd2, 5'd1, 32'h2222_0000);
        f[2] = mk(5'd1, 5'd2, 32'h3333_0000);
        f[3] = mk(5'd3, 5'd2, 32'h4444_0000);
        f[4] = mk(5'd2, 5'd2, 32'h5555_0000);
        for (int p = 0; p < NP; p++) in_flit[p*FW +: FW] = f[p];
        in_valid  = 5'h1F;
        out_ready = 5'h1F;
        tick();
        in_valid = '0;
        check("R9 all valid", 80'(out_valid), 80'h1F);
        check("R9 south lane", out_flit[1*FW +: FW], f[0]);
        check("R9 north lane", out_flit[0*FW +: FW], f[1]);
        check("R9 west lane", out_flit[3*FW +: FW], f[2]);
        check("R9 east lane", out_flit[2*FW +: FW], f[3]);
        check("R9 local lane", out_flit[4*FW +: FW], f[4]);
        tick();
        check("R9 all left together", 80'(out_valid), 80'h0);
        out_ready = '0;
    endtask

    initial begin
        #(4 * 100000);
        fails++;
        checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_route();
        t_fifo();
        t_rr();
        t_stall();
        t_parallel();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule